// File: doc/BRIEF.md
# Two-Input Dataflow Actor Unit

This block executes a single actor of a homogeneous dataflow graph. The actor has two operand links, A and B, and one result link, Y. Each link is a data bus with a full flag that shows a token is present. The actor fires on a clock edge when both operand links are full and its own result link is empty. Firing takes both operand tokens in that cycle. Depending on the selected operation, firing also places one result token on Y or places nothing.

Conditional routing in the graph uses only data tokens. A pass actor forwards operand A, or it drops the pair without producing a token. No separate control-token actors are needed. A 4-bit operation code is loaded by a configuration strobe. It then holds while the graph runs. The result token stays on Y until the downstream consumer acknowledges it. The actor cannot fire again until that token has been cleared.

Top module: `actor_unit`

## Requirements
- R1: After reset, `y_full`, `a_take` and `b_take` are 0, and the operation is ADD (code 0).
- R2: `a_take` is high in a cycle exactly when `a_full`, `b_full` are high and `y_full` is low. A single present operand never fires.
- R3: `a_take` and `b_take` are always equal, so both operands are taken in the same cycle. This also holds when no result is produced.
- R4: A firing that produces a result sets `y_full` on that clock edge. `y_data` then holds the result and does not change until the token is acknowledged.
- R5: While `y_full` is high and `y_ack` is low, `y_full` stays high and no firing happens. `y_ack` with `y_full` high clears `y_full` on the next edge. Without a firing, `y_full` never rises.
- R6: Codes 0, 1 and 2 produce A+B, A−B and A×B as 16-bit two's-complement values, keeping the low 16 bits.
- R7: Codes 3 (A>B), 4 (A≤B) and 5 (A==B) compare the operands as signed values. They produce 1 when the relation holds and 0 otherwise.
- R8: Code 6 forwards A when B is nonzero. Code 7 forwards A when B is zero. Otherwise nothing is produced.
- R9: Code 8 forwards A when A≤B, compared as signed values. Otherwise nothing is produced.
- R10: Codes 9 to 15 take both operands and never produce a result.
- R11: `cfg_op` is loaded only in a cycle with `cfg_we` high. While `cfg_we` is low, changes on `cfg_op` have no effect on later firings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Load strobe for the operation code |
| cfg_op | input | 4 | Operation code |
| a_data | input | W | Operand A token value |
| a_full | input | 1 | Operand A token present |
| a_take | output | 1 | Operand A token consumed this cycle |
| b_data | input | W | Operand B token value |
| b_full | input | 1 | Operand B token present |
| b_take | output | 1 | Operand B token consumed this cycle |
| y_data | output | W | Result token value |
| y_full | output | 1 | Result token present |
| y_ack | input | 1 | Downstream has taken the result token |

## Verification
The bench builds the unit with the default width of 16 bits. At this width the signed extremes −32768 and 32767 are reachable directly. Multiplication wraps, and signed and unsigned ordering differ, so the comparison and conditional-pass codes are tested where the sign bit decides the outcome. Random operation codes cover all sixteen values, including the reserved ones. Operand pairs are often made equal or zero, so that every pass condition hits both its true and its false branch.

// File: rtl/actor_pkg.sv
`timescale 1ns/1ps
package actor_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD     = 4'd0,
    OP_SUB     = 4'd1,
    OP_MUL     = 4'd2,
    OP_GT      = 4'd3,
    OP_LE      = 4'd4,
    OP_EQ      = 4'd5,
    OP_PASS_T  = 4'd6,
    OP_PASS_F  = 4'd7,
    OP_PASS_LE = 4'd8
  } actor_op_e;
endpackage

// File: rtl/actor_fire_ctrl.sv
`timescale 1ns/1ps
// Firing rule: both operand links full, result link empty, unit out of reset.
module actor_fire_ctrl (
  input  logic run,
  input  logic a_full,
  input  logic b_full,
  input  logic out_full,
  output logic fire
);
  always_comb begin
    fire = run & a_full & b_full & ~out_full;
  end
endmodule

// File: rtl/actor_alu.sv
`timescale 1ns/1ps
// Computes the result value and whether a token is emitted for it.
module actor_alu
  import actor_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res,
  output logic            emit
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic a_gt_b, a_eq_b, b_nz;

  always_comb begin
    a_gt_b = $signed(a) > $signed(b);
    a_eq_b = (a == b);
    b_nz   = |b;
  end

  always_comb begin
    res  = a;
    emit = 1'b1;
    case (op)
      OP_ADD:     res = a + b;
      OP_SUB:     res = a - b;
      OP_MUL:     res = a * b;
      OP_GT:      res = a_gt_b ? ONE : ZERO;
      OP_LE:      res = a_gt_b ? ZERO : ONE;
      OP_EQ:      res = a_eq_b ? ONE : ZERO;
      OP_PASS_T:  emit = b_nz;
      OP_PASS_F:  emit = ~b_nz;
      OP_PASS_LE: emit = ~a_gt_b;
      default:    emit = 1'b0;
    endcase
  end
endmodule

// File: rtl/actor_out_reg.sv
`timescale 1ns/1ps
// Result link register: set on a producing firing, cleared by acknowledge.
module actor_out_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ack,
  output logic         out_full,
  output logic [W-1:0] out_data
);
  logic full_d;
  logic data_en;

  always_comb begin
    data_en = load;
    full_d  = out_full;
    if (out_full && ack) full_d = 1'b0;
    if (load)            full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_full <= 1'b0;
    else        out_full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_data <= '0;
    else if (data_en) out_data <= load_data;
  end
endmodule

// File: rtl/actor_unit.sv
`timescale 1ns/1ps
module actor_unit
  import actor_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [OP_W-1:0] cfg_op,
  input  logic [W-1:0]    a_data,
  input  logic            a_full,
  output logic            a_take,
  input  logic [W-1:0]    b_data,
  input  logic            b_full,
  output logic            b_take,
  output logic [W-1:0]    y_data,
  output logic            y_full,
  input  logic            y_ack
);
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              run;
  logic [OP_W-1:0]   op_q, op_d;
  logic              fire, emit;
  logic [W-1:0]      res;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign run = rst_pipe[SYNC_N-1];

  always_comb begin
    op_d = op_q;
    if (cfg_we) op_d = cfg_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_ADD;
    else        op_q <= op_d;
  end

  actor_fire_ctrl u_fire (
    .run      (run),
    .a_full   (a_full),
    .b_full   (b_full),
    .out_full (y_full),
    .fire     (fire)
  );

  actor_alu #(.W(W)) u_alu (
    .op   (op_q),
    .a    (a_data),
    .b    (b_data),
    .res  (res),
    .emit (emit)
  );

  actor_out_reg #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire & emit),
    .load_data (res),
    .ack       (y_ack),
    .out_full  (y_full),
    .out_data  (y_data)
  );

  assign a_take = fire;
  assign b_take = fire;
endmodule

// File: rtl/actor_unit_chk.sv
`timescale 1ns/1ps
module actor_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_full,
  input logic         b_full,
  input logic         a_take,
  input logic         b_take,
  input logic         y_full,
  input logic         y_ack,
  input logic [W-1:0] y_data
);
  AST_FIRE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    a_take |-> (a_full && b_full && !y_full)); // R2
  AST_TAKE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    a_take == b_take); // R3
  AST_HOLD_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (y_full && !y_ack) |=> (y_full && $stable(y_data))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (y_full && y_ack) |=> !y_full); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!y_full && !a_take) |=> !y_full); // R5
  AST_NO_FIRE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    y_full |-> !a_take); // R5
endmodule

bind actor_unit actor_unit_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_full (a_full),
  .b_full (b_full),
  .a_take (a_take),
  .b_take (b_take),
  .y_full (y_full),
  .y_ack  (y_ack),
  .y_data (y_data)
);

// File: tb/sim_actor_unit.sv
`timescale 1ns/1ps
module sim_actor_unit;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [3:0]   cfg_op;
  logic [W-1:0] a_data, b_data;
  logic         a_full, b_full, y_ack;
  logic         a_take, b_take, y_full;
  logic [W-1:0] y_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  actor_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .a_data(a_data), .a_full(a_full), .a_take(a_take),
    .b_data(b_data), .b_full(b_full), .b_take(b_take),
    .y_data(y_data), .y_full(y_full), .y_ack(y_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                                output bit em, output logic [W-1:0] v);
    logic signed [W-1:0] sa, sb;
    sa = a; sb = b; em = 1; v = a;
    case (op)
      4'd0: v = W'(a + b);
      4'd1: v = W'(a - b);
      4'd2: v = W'(32'(a) * 32'(b));
      4'd3: v = (sa > sb) ? 1 : 0;
      4'd4: v = (sa <= sb) ? 1 : 0;
      4'd5: v = (a == b) ? 1 : 0;
      4'd6: em = (b != 0);
      4'd7: em = (b == 0);
      4'd8: em = (sa <= sb);
      default: em = 0;
    endcase
  endfunction

  task automatic load_op(input logic [3:0] op);
    @(negedge clk); cfg_we = 1; cfg_op = op;
    @(negedge clk); cfg_we = 0;
  endtask

  // present one operand pair, expect firing, check result, acknowledge it
  task automatic fire_one(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    bit em; logic [W-1:0] v;
    model(op, a, b, em, v);
    @(negedge clk);
    a_data = a; b_data = b; a_full = 1; b_full = 1;
    #1;
    check({req, " R2 fire"}, {31'd0, a_take}, 32'd1);
    check({req, " R3 pair"}, {31'd0, b_take}, 32'd1);
    @(negedge clk);
    a_full = 0; b_full = 0;
    check({req, " R4 full"}, {31'd0, y_full}, {31'd0, em});
    if (em) begin
      check({req, " R4 data"}, {16'd0, y_data}, {16'd0, v});
      y_ack = 1;
      @(negedge clk);
      y_ack = 0;
      check({req, " R5 ack"}, {31'd0, y_full}, 32'd0);
    end
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom % 8)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      4: return 16'h8000;
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 0; cfg_we = 0; cfg_op = 0; a_data = 0; b_data = 0;
    a_full = 0; b_full = 0; y_ack = 0;
    repeat (3) @(negedge clk);
    check("R1 y_full in reset", {31'd0, y_full}, 32'd0);
    check("R1 take in reset", {31'd0, a_take}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 y_full after reset", {31'd0, y_full}, 32'd0);

    // default operation is ADD
    fire_one(4'd0, 16'd1200, 16'd34, "R1 default add");

    // single operand present never fires
    @(negedge clk); a_full = 1; a_data = 16'd5;
    repeat (3) begin
      @(negedge clk);
      check("R2 only A", {30'd0, a_take, y_full}, 32'd0);
    end
    a_full = 0; b_full = 1; b_data = 16'd6;
    repeat (3) begin
      @(negedge clk);
      check("R2 only B", {30'd0, b_take, y_full}, 32'd0);
    end
    b_full = 0;

    // R6 directed wrap cases
    load_op(4'd0); fire_one(4'd0, 16'h7FFF, 16'h0001, "R6 add wrap");
    load_op(4'd1); fire_one(4'd1, 16'h8000, 16'h0001, "R6 sub wrap");
    load_op(4'd2); fire_one(4'd2, 16'h0100, 16'h0101, "R6 mul low");
    // R7 signed ordering
    load_op(4'd3); fire_one(4'd3, 16'h0001, 16'hFFFF, "R7 gt signed");
    load_op(4'd4); fire_one(4'd4, 16'h8000, 16'h7FFF, "R7 le signed");
    load_op(4'd5); fire_one(4'd5, 16'h1234, 16'h1234, "R7 eq");
    // R8 pass on B truth
    load_op(4'd6); fire_one(4'd6, 16'hABCD, 16'h0000, "R8 passT drop");
    fire_one(4'd6, 16'hABCD, 16'h0002, "R8 passT fwd");
    load_op(4'd7); fire_one(4'd7, 16'h0042, 16'h0000, "R8 passF fwd");
    fire_one(4'd7, 16'h0042, 16'h8000, "R8 passF drop");
    // R9 compare pass
    load_op(4'd8); fire_one(4'd8, 16'hFFFE, 16'h0003, "R9 pass le");
    fire_one(4'd8, 16'h0003, 16'h0003, "R9 pass eq");
    fire_one(4'd8, 16'h0004, 16'h0003, "R9 drop gt");
    // R10 reserved codes
    load_op(4'd9);  fire_one(4'd9,  16'd1, 16'd2, "R10 code9");
    load_op(4'd15); fire_one(4'd15, 16'd1, 16'd2, "R10 code15");

    // R11 cfg_op without strobe is ignored (op stays SUB)
    load_op(4'd1);
    @(negedge clk); cfg_op = 4'd0;
    fire_one(4'd1, 16'd10, 16'd3, "R11 no strobe");

    // R4/R5 hold: token stays, no firing until acknowledged
    load_op(4'd0);
    @(negedge clk); a_data = 16'd7; b_data = 16'd8; a_full = 1; b_full = 1;
    @(negedge clk); a_full = 0; b_full = 0;
    check("R4 hold set", {16'd0, y_data}, 32'd15);
    @(negedge clk); a_data = 16'd100; b_data = 16'd1; a_full = 1; b_full = 1;
    repeat (3) begin
      #1;
      check("R5 blocked", {31'd0, a_take}, 32'd0);
      @(negedge clk);
      check("R4 stable", {15'd0, y_full, y_data}, {15'd0, 1'b1, 16'd15});
    end
    y_ack = 1;
    @(negedge clk); y_ack = 0;
    check("R5 cleared", {31'd0, y_full}, 32'd0);
    #1; check("R2 refire", {31'd0, a_take}, 32'd1);
    @(negedge clk); a_full = 0; b_full = 0;
    check("R4 new token", {15'd0, y_full, y_data}, {15'd0, 1'b1, 16'd101});
    y_ack = 1; @(negedge clk); y_ack = 0;

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [3:0] op; logic [W-1:0] a, b;
      op = 4'($urandom);
      a = pick();
      b = ($urandom % 4 == 0) ? a : pick();
      load_op(op);
      fire_one(op, a, b, "R6-R10 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule